// File: doc/BRIEF.md
# Dual-Channel Serial ADC Frame Reader

This block sits on the host side of a three-wire serial link to a two-channel converter that samples both channels at once. When `start` is pulsed, the reader pulls chip select low, which starts a conversion. It then makes a configured number of serial clock cycles from the system clock. On each serial clock rising edge it samples the data lines. It discards the framing zeros and returns the two 12-bit results together through a valid/ready output.

A frame can run in three ways. In the two short dual-line ways, 14 or 16 clocks are issued and each channel arrives on its own data line. In the single-line way, 32 clocks are issued and both channels arrive one after the other on line A, each in a 16-bit slot. The clock divider, the frame mode and the minimum chip-select quiet time are all captured when a start is accepted. The result output obeys valid/ready back-pressure. Once `res_valid` is high, the result words stay frozen until `res_ready` is seen high on a clock edge. Until that handshake, the reader stays busy and accepts no new start, so a result is never overwritten.

Top module: `adcrd_frame_reader`

## Requirements
- R1: While reset is active and directly after it, `cs_n` = 1, `sclk` = 1, `busy` = 0 and `res_valid` = 0.
- R2: A start accepted on clock edge T drives `cs_n` low from T. `sclk` stays high for H cycles and then toggles with H cycles per half period. H = `cfg_div` as latched at T, and a value of 0 is used as 1.
- R3: `cfg_mode` selects the number of serial clock cycles per frame: 0 gives 14 with two lines, 1 gives 16 with two lines, 2 gives 32 with one line, and 3 behaves as 1.
- R4: `cs_n` rises H cycles after the last serial clock rising edge. `sclk` is high whenever `cs_n` is high.
- R5: Number the serial clock rising edges within a frame from 1. In the two-line modes, `res_a` is built MSB first from `sdata_a` at rising edges 2 to 13, and `res_b` is built the same way from `sdata_b`. Line values at every other rising edge have no effect on the result.
- R6: In single-line mode, `res_a` comes from `sdata_a` at rising edges 2 to 13 and `res_b` comes from `sdata_a` at rising edges 18 to 29, both MSB first. `sdata_b` has no effect.
- R7: `res_valid` rises on the same edge on which `cs_n` rises. While `res_valid` is high and `res_ready` is low, `res_valid`, `res_a` and `res_b` keep their values. `res_valid` drops on the edge that follows a cycle in which both are high.
- R8: `busy` is high from the accepting edge until the quiet time has ended and the result has been taken. A `start` seen while `busy` is high has no effect.
- R9: After `cs_n` rises, it stays high for at least Q cycles before it can fall again, where Q = `cfg_quiet` as latched for that frame. With Q = 0, a new frame may start on the cycle after the result is taken.
- R10: A change on `cfg_mode`, `cfg_div` or `cfg_quiet` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame request, accepted only when not busy |
| cfg_mode | input | 2 | Frame mode (see R3) |
| cfg_div | input | DIV_W | System cycles per serial clock half period |
| cfg_quiet | input | Q_W | Minimum chip-select high time between frames |
| busy | output | 1 | Frame, quiet time or unread result in progress |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdata_a | input | 1 | Serial data line A |
| sdata_b | input | 1 | Serial data line B |
| res_valid | output | 1 | Result pair valid |
| res_ready | input | 1 | Result consumer ready |
| res_a | output | 12 | Channel A result |
| res_b | output | 12 | Channel B result |

## Verification
The assertions assume that the converter changes its data lines only right after a serial clock falling edge and holds them until the next rising edge. They also assume that the data lines are synchronous to the system clock, so each line can be sampled on the system edge that raises `sclk`. The bench's converter model meets these assumptions. It updates the lines in the same time step as each falling edge it observes, and every half period is at least one system cycle long. The bench varies `res_ready` and `start` freely, because the reader must tolerate any pattern on them. It also includes frames whose framing positions carry ones instead of zeros, to show that only the defined bit windows reach the results.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  localparam int unsigned WORD_W   = 12;
  localparam int unsigned LEAD_Z   = 2;
  localparam int unsigned SLOT_LEN = 16;
  localparam int unsigned IDX_W    = $clog2(2 * SLOT_LEN + 1);

  typedef enum logic [1:0] {
    MODE_DUAL_SHORT = 2'd0,
    MODE_DUAL_SLOT  = 2'd1,
    MODE_ONE_LINE   = 2'd2,
    MODE_SPARE      = 2'd3
  } rd_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_QUIET = 3'd4
  } seq_state_e;

  // serial clock cycles issued per frame for a mode code
  function automatic logic [IDX_W-1:0] clocks_for(input logic [1:0] m);
    case (rd_mode_e'(m))
      MODE_DUAL_SHORT: return IDX_W'(LEAD_Z + WORD_W);
      MODE_ONE_LINE:   return IDX_W'(2 * SLOT_LEN);
      default:         return IDX_W'(SLOT_LEN);
    endcase
  endfunction
endpackage

// File: rtl/adcrd_tick_timer.sv
module adcrd_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt_q;

  assign done = run && (cnt_q == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || done)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + W'(1);
  end

  // a running interval needs a non-zero length (R2)
  p_run_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (limit != '0));
endmodule

// File: rtl/adcrd_sequencer.sv
module adcrd_sequencer
  import adcrd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int Q_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [Q_W-1:0]   cfg_quiet,
  input  logic             res_ready,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  output logic             res_valid,
  output logic             rise_evt,
  output logic [IDX_W-1:0] rise_idx,
  output logic             single_line
);
  seq_state_e       state_q;
  logic [DIV_W-1:0] div_q;
  logic [Q_W-1:0]   quiet_q;
  logic [IDX_W-1:0] nclk_q, edge_q;
  logic             single_q, cs_n_q, sclk_q, valid_q;
  logic             accept, ph_run, ph_done, qt_run, qt_done, last_edge;

  assign accept    = (state_q == ST_IDLE) && start && !valid_q;
  assign ph_run    = (state_q == ST_SETUP) || (state_q == ST_LOW) || (state_q == ST_HIGH);
  assign qt_run    = (state_q == ST_QUIET);
  assign last_edge = (edge_q == nclk_q);
  assign rise_evt  = (state_q == ST_LOW) && ph_done;
  assign rise_idx  = edge_q + IDX_W'(1);

  adcrd_tick_timer #(.W(DIV_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(ph_run), .limit(div_q), .done(ph_done));

  adcrd_tick_timer #(.W(Q_W)) u_quiet (
    .clk(clk), .rst_n(rst_n), .run(qt_run), .limit(quiet_q), .done(qt_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      div_q    <= DIV_W'(1);
      quiet_q  <= '0;
      nclk_q   <= IDX_W'(SLOT_LEN);
      edge_q   <= '0;
      single_q <= 1'b0;
      cs_n_q   <= 1'b1;
      sclk_q   <= 1'b1;
      valid_q  <= 1'b0;
    end else begin
      if (valid_q && res_ready) valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q  <= ST_SETUP;
          cs_n_q   <= 1'b0;
          edge_q   <= '0;
          div_q    <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
          quiet_q  <= cfg_quiet;
          nclk_q   <= clocks_for(cfg_mode);
          single_q <= (cfg_mode == MODE_ONE_LINE);
        end
        ST_SETUP: if (ph_done) begin
          state_q <= ST_LOW;
          sclk_q  <= 1'b0;
        end
        ST_LOW: if (ph_done) begin
          state_q <= ST_HIGH;
          sclk_q  <= 1'b1;
          edge_q  <= rise_idx;
        end
        ST_HIGH: if (ph_done) begin
          if (last_edge) begin
            cs_n_q  <= 1'b1;
            valid_q <= 1'b1;
            state_q <= (quiet_q == '0) ? ST_IDLE : ST_QUIET;
          end else begin
            state_q <= ST_LOW;
            sclk_q  <= 1'b0;
          end
        end
        ST_QUIET: if (qt_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE) || valid_q;
  assign cs_n        = cs_n_q;
  assign sclk        = sclk_q;
  assign res_valid   = valid_q;
  assign single_line = single_q;

  // ---- checking state: rising edges seen and chip-select high time ----
  logic             sclk_d;
  logic [IDX_W:0]   rises_q;
  logic [Q_W:0]     gap_q;
  logic [Q_W-1:0]   gap_req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d    <= 1'b1;
      rises_q   <= '0;
      gap_q     <= '0;
      gap_req_q <= '0;
    end else begin
      sclk_d <= sclk_q;
      if (cs_n_q)                rises_q <= '0;
      else if (sclk_q && !sclk_d) rises_q <= rises_q + (IDX_W+1)'(1);
      if (!cs_n_q) begin
        gap_q     <= '0;
        gap_req_q <= quiet_q;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + (Q_W+1)'(1);
      end
    end
  end

  p_edge_total_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (rises_q == {1'b0, nclk_q}));

  p_sclk_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> sclk_q);

  p_pending_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> cs_n_q);

  p_quiet_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> ($past(gap_q) >= {1'b0, $past(gap_req_q)}));
endmodule

// File: rtl/adcrd_shifter.sv
module adcrd_shifter
  import adcrd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_evt,
  input  logic [IDX_W-1:0]  rise_idx,
  input  logic              single_line,
  input  logic              sd_a,
  input  logic              sd_b,
  output logic [WORD_W-1:0] word_a,
  output logic [WORD_W-1:0] word_b
);
  localparam logic [IDX_W-1:0] A_FIRST = IDX_W'(LEAD_Z);
  localparam logic [IDX_W-1:0] A_LAST  = IDX_W'(LEAD_Z + WORD_W - 1);
  localparam logic [IDX_W-1:0] B_FIRST = IDX_W'(SLOT_LEN + LEAD_Z);
  localparam logic [IDX_W-1:0] B_LAST  = IDX_W'(SLOT_LEN + LEAD_Z + WORD_W - 1);

  logic in_first, in_second;
  logic [1:0] lane_en, lane_bit;
  logic [WORD_W-1:0] lane_q [2];

  assign in_first  = (rise_idx >= A_FIRST) && (rise_idx <= A_LAST);
  assign in_second = (rise_idx >= B_FIRST) && (rise_idx <= B_LAST);

  always_comb begin
    lane_en[0]  = rise_evt && in_first;
    lane_bit[0] = sd_a;
    if (single_line) begin
      lane_en[1]  = rise_evt && in_second;
      lane_bit[1] = sd_a;
    end else begin
      lane_en[1]  = rise_evt && in_first;
      lane_bit[1] = sd_b;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lane_q[g] <= '0;
      else if (lane_en[g]) lane_q[g] <= {lane_q[g][WORD_W-2:0], lane_bit[g]};
    end
  end

  assign word_a = lane_q[0];
  assign word_b = lane_q[1];

  // the two slot windows of one line never overlap (R6)
  p_slot_disjoint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |-> !(in_first && in_second));
endmodule

// File: rtl/adcrd_frame_reader.sv
module adcrd_frame_reader
  import adcrd_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int Q_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [Q_W-1:0]    cfg_quiet,
  output logic              busy,
  output logic              cs_n,
  output logic              sclk,
  input  logic              sdata_a,
  input  logic              sdata_b,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_a,
  output logic [WORD_W-1:0] res_b
);
  logic             rise_evt, single_line;
  logic [IDX_W-1:0] rise_idx;

  adcrd_sequencer #(.DIV_W(DIV_W), .Q_W(Q_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_div(cfg_div), .cfg_quiet(cfg_quiet), .res_ready(res_ready),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .res_valid(res_valid),
    .rise_evt(rise_evt), .rise_idx(rise_idx), .single_line(single_line));

  adcrd_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .rise_idx(rise_idx),
    .single_line(single_line), .sd_a(sdata_a), .sd_b(sdata_b),
    .word_a(res_a), .word_b(res_b));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_a) && $stable(res_b)));
endmodule

// File: tb/adcrd_frame_reader_test.sv
`timescale 1ns/1ps
module adcrd_frame_reader_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       start = 1'b0, res_ready = 1'b0;
  logic [1:0] cfg_mode = 2'd1;
  logic [7:0] cfg_div = 8'd1, cfg_quiet = 8'd0;
  logic       busy, cs_n, sclk, res_valid;
  logic       sda = 1'b0, sdb = 1'b0;
  logic [11:0] res_a, res_b;

  adcrd_frame_reader uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_div(cfg_div), .cfg_quiet(cfg_quiet), .busy(busy), .cs_n(cs_n),
    .sclk(sclk), .sdata_a(sda), .sdata_b(sdb), .res_valid(res_valid),
    .res_ready(res_ready), .res_a(res_a), .res_b(res_b));

  int checks = 0, fails = 0;
  string tag = "R1";

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---- converter model: bit n is driven after the n-th falling edge ----
  logic [11:0] dev_a = '0, dev_b = '0;
  logic        dev_dirty = 1'b0;
  logic [31:0] strm_a = '0, strm_b = '0;
  int          didx = 0;

  always @(negedge cs_n) begin
    logic [1:0] fz;
    fz = dev_dirty ? 2'b11 : 2'b00;
    if (cfg_mode == 2'd2) begin
      strm_a = {fz, dev_a, fz, fz, dev_b, fz};
      strm_b = 32'h5A5A_A5A5;
    end else begin
      strm_a = {fz, dev_a, fz, {8{fz}}};
      strm_b = {fz, dev_b, fz, {8{fz}}};
    end
    didx = 0;
    sda = strm_a[31];
    sdb = strm_b[31];
  end

  always @(negedge sclk) begin
    if (cs_n === 1'b0) begin
      didx++;
      sda = (didx < 32) ? strm_a[31-didx] : 1'b0;
      sdb = (didx < 32) ? strm_b[31-didx] : 1'b0;
    end
  end

  always @(posedge cs_n) begin
    sda = 1'b0;
    sdb = 1'b0;
  end

  // ---- reference model of pin waveform and result stream ----
  typedef struct { logic cs; logic sc; bit fin; } ent_t;
  ent_t        mq[$];
  int          m_quiet = 0, fr_quiet = 0;
  bit          m_pend = 1'b0;
  logic [11:0] fr_a = '0, fr_b = '0, ex_a = '0, ex_b = '0;

  function automatic bit m_busy();
    return (mq.size() != 0) || (m_quiet > 0) || m_pend;
  endfunction

  task automatic push_frame();
    int h, n;
    h = (cfg_div == 0) ? 1 : int'(cfg_div);
    n = (cfg_mode == 2'd0) ? 14 : (cfg_mode == 2'd2) ? 32 : 16;
    repeat (h) mq.push_back('{1'b0, 1'b1, 1'b0});
    for (int k = 0; k < n; k++) begin
      repeat (h) mq.push_back('{1'b0, 1'b0, 1'b0});
      repeat (h) mq.push_back('{1'b0, 1'b1, 1'b0});
    end
    mq.push_back('{1'b1, 1'b1, 1'b1});
    fr_quiet = int'(cfg_quiet);
    fr_a = dev_a;
    fr_b = dev_b;
  endtask

  task automatic cyc(input logic st, input logic rdy);
    ent_t cur;
    bit   bpre;
    bpre = m_busy();
    start = st;
    res_ready = rdy;
    if (m_pend && rdy) m_pend = 1'b0;
    if (st && !bpre) push_frame();
    cur = '{1'b1, 1'b1, 1'b0};
    if (mq.size() != 0) begin
      cur = mq.pop_front();
      if (cur.fin) begin
        m_pend = 1'b1;
        m_quiet = fr_quiet;
        ex_a = fr_a;
        ex_b = fr_b;
      end
    end else if (m_quiet > 0) begin
      m_quiet--;
    end
    @(posedge clk);
    @(negedge clk);
    chk("cs_n", 32'(cs_n), 32'(cur.cs));
    chk("sclk", 32'(sclk), 32'(cur.sc));
    chk("res_valid", 32'(res_valid), 32'(m_pend));
    chk("busy", 32'(busy), 32'(m_busy()));
    if (m_pend) begin
      chk("res_a", 32'(res_a), 32'(ex_a));
      chk("res_b", 32'(res_b), 32'(ex_b));
    end
  endtask

  task automatic drain(input logic rdy);
    int guard = 0;
    while (m_busy() && guard < 2000) begin
      cyc(1'b0, rdy);
      guard++;
    end
  endtask

  task automatic frame(input logic [1:0] md, input logic [7:0] dv, input logic [7:0] qt,
                       input logic [11:0] a, input logic [11:0] b, input logic dirty);
    cfg_mode = md; cfg_div = dv; cfg_quiet = qt;
    dev_a = a; dev_b = b; dev_dirty = dirty;
    cyc(1'b1, 1'b1);
    drain(1'b1);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    chk("cs_n", 32'(cs_n), 32'd1);
    chk("sclk", 32'(sclk), 32'd1);
    chk("busy", 32'(busy), 32'd0);
    chk("res_valid", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    cyc(1'b0, 1'b1);

    tag = "R2";  // half period and setup length from divider
    frame(2'd1, 8'd3, 8'd2, 12'hA5C, 12'h3F1, 1'b0);
    tag = "R3";  // 14-clock dual-line mode
    frame(2'd0, 8'd1, 8'd1, 12'h801, 12'h7FE, 1'b0);
    tag = "R4";  // spare code as 16 clocks, divider 0 used as 1
    frame(2'd3, 8'd0, 8'd0, 12'hFFF, 12'h000, 1'b0);
    tag = "R5";  // ones in framing positions must not reach results
    frame(2'd1, 8'd2, 8'd1, 12'h123, 12'hEDC, 1'b1);
    frame(2'd0, 8'd1, 8'd0, 12'h000, 12'hFFF, 1'b1);
    tag = "R6";  // single line, line B carries noise
    frame(2'd2, 8'd1, 8'd1, 12'hC3A, 12'h5E7, 1'b0);
    frame(2'd2, 8'd2, 8'd0, 12'h0F0, 12'hF0F, 1'b1);

    tag = "R7";  // back-pressure on result
    cfg_mode = 2'd1; cfg_div = 8'd1; cfg_quiet = 8'd0;
    dev_a = 12'h9B4; dev_b = 12'h26D; dev_dirty = 1'b0;
    cyc(1'b1, 1'b0);
    drain_hold: for (int i = 0; i < 60; i++) cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b1);
    cyc(1'b0, 1'b1);

    tag = "R8";  // start held high through frame and pending result
    cfg_mode = 2'd0; cfg_div = 8'd2; cfg_quiet = 8'd3;
    dev_a = 12'h456; dev_b = 12'hBA9;
    cyc(1'b1, 1'b0);
    while (mq.size() != 0) cyc(1'b1, 1'b0);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0);
    drain(1'b1);

    tag = "R9";  // quiet time, then back-to-back with zero quiet
    cfg_mode = 2'd1; cfg_div = 8'd1; cfg_quiet = 8'd5;
    dev_a = 12'h111; dev_b = 12'h222;
    cyc(1'b1, 1'b1);
    for (int i = 0; i < 60; i++) cyc(1'b1, 1'b1);
    cfg_quiet = 8'd0;
    for (int i = 0; i < 80; i++) cyc(1'b1, 1'b1);
    drain(1'b1);

    tag = "R10"; // configuration changes mid-frame
    cfg_mode = 2'd1; cfg_div = 8'd2; cfg_quiet = 8'd2;
    dev_a = 12'h6C9; dev_b = 12'h93E;
    cyc(1'b1, 1'b1);
    cfg_mode = 2'd2; cfg_div = 8'd1; cfg_quiet = 8'd0;
    drain(1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule